// File: doc/BRIEF.md
# Video FIFO underflow concealment unit

This unit reads 8-bit 4:2:2 video bytes from a pixel FIFO and places them on a pixel-clocked output port. A bus DMA engine fills the FIFO elsewhere. The timing comes from outside the unit: a pixel clock enable, horizontal sync, vertical sync and a field identifier. After each horizontal sync the unit waits a programmed number of pixel periods. It then emits a programmed number of bytes and raises a qualifier strobe with each one. Horizontal offset and line length are taken into shadow registers only at vertical sync.

When the FIFO runs dry, behaviour depends on a run-time mode bit.

- **Direct mode** keeps the line running. It fills each empty slot with a fixed grey byte or with a repeat of the last good byte. It counts the misses and later throws away that many late FIFO entries, so that the line ends in alignment.
- **Line-memory mode** never invents data. The qualifier stays low while the FIFO is empty and output resumes when data arrives. Every horizontal sync restarts the line. In this mode the qualifier serves as the write enable of a downstream line store.

The FIFO is reached only through its empty flag, its head byte and a registered read strobe. The pixel enable must be high for at most one clock in every four. This leaves a free clock between pixels in which one late entry can be discarded.

Top module: `vid_underflow_conceal`

## Requirements
- R1: After reset, `vid_qual_o`, `fifo_rd_o`, `vid_field_o` and `vid_data_o` are all zero, and no byte is emitted before the first vertical sync.
- R2: Horizontal offset, line length and field are captured when `vsync_i` is high on a pixel-enable cycle. Changes to `cfg_hoff_i`, `cfg_len_i` or `field_i` at other times have no effect on output timing or on `vid_field_o`.
- R3: A pixel-enable cycle with `hsync_i` high is the sync slot. With offset N, the first byte of the line appears on the (N+1)-th pixel enable after the sync slot. Exactly the programmed number of bytes are emitted, or made to wait for, and then nothing until the next horizontal sync.
- R4: `vid_qual_o` is high for exactly the pixel periods that carry a byte. Good bytes come from the FIFO head in FIFO order, with one FIFO read per byte taken.
- R5: In direct mode with grey fill (`cfg_hold_last_i`=0), an empty slot at an even byte index outputs 0x80 (chroma, Cb/Cr). An empty slot at an odd byte index outputs 0x10 (luma, Y). The index counts from 0 at the first byte of the line.
- R6: In direct mode with last-byte fill (`cfg_hold_last_i`=1), an empty slot repeats the most recent byte taken from the FIFO.
- R7: In direct mode, each empty slot adds one to a miss count. While the count is non-zero and the FIFO holds data, one entry per pixel period is read and discarded in the free clock after the pixel. Each discard lowers the count by one.
- R8: The miss count is cleared at every horizontal sync, so misses from one line never discard data of the next line. The count never exceeds the line length.
- R9: Vertical sync clears the byte index and the miss count, and sets the last-byte register to 0x80.
- R10: In line-memory mode (`cfg_line_mode_i`=1), an empty slot emits nothing. The qualifier stays low, the byte index holds and no entry is discarded. Output resumes with the next FIFO byte.
- R11: In line-memory mode, a horizontal sync restarts the offset wait and the byte index even if the current line is unfinished.
- R12: `fifo_rd_o` is registered and never high on two consecutive clocks. A discard read never coincides with an output read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel clock enable, at most one clock in four |
| hsync_i | input | 1 | Horizontal sync, sampled on pixel enable |
| vsync_i | input | 1 | Vertical sync, sampled on pixel enable |
| field_i | input | 1 | Field identifier, captured at vertical sync |
| cfg_line_mode_i | input | 1 | 1 = line-memory (wait) mode, 0 = direct (conceal) mode |
| cfg_hold_last_i | input | 1 | Direct fill: 1 = repeat last byte, 0 = grey |
| cfg_hoff_i | input | 12 | Horizontal offset in pixel periods |
| cfg_len_i | input | 12 | Bytes per line |
| fifo_data_i | input | 8 | FIFO head byte |
| fifo_empty_i | input | 1 | FIFO empty flag |
| fifo_rd_o | output | 1 | Registered FIFO pop strobe |
| vid_data_o | output | 8 | Output video byte |
| vid_qual_o | output | 1 | Byte qualifier / line-store write enable |
| vid_field_o | output | 1 | Field of the current frame |

## Verification
A wrong byte index or a wrong offset counter shows up at the first byte of the next line. The byte then arrives in the wrong pixel slot, or the grey value has the wrong parity, and the slot-stamped scoreboard reports it at once. A miss count that is wrong, or that is not cleared, appears within a pixel period or two as an extra or a missing FIFO read. It shows as a shifted byte on the port, or as FIFO occupancy that differs from the expected remainder at the end of the line. A wrong last-byte register shows on the first empty slot of a frame.

// File: rtl/vuc_pkg.sv
package vuc_pkg;
  localparam int unsigned PIX_W = 8;
  localparam int unsigned CNT_W = 12;
  localparam int unsigned GREY_Y = 16;
  localparam int unsigned GREY_C = 128;

  typedef enum logic [1:0] {
    LN_IDLE,
    LN_OFFSET,
    LN_ACTIVE
  } line_st_e;
endpackage

// File: rtl/vuc_timing.sv
module vuc_timing
  import vuc_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_en_i,
  input  logic          hsync_i,
  input  logic          vsync_i,
  input  logic          field_i,
  input  logic [CW-1:0] hoff_i,
  input  logic [CW-1:0] len_i,
  input  logic          advance_i,
  output logic          slot_o,
  output logic          hs_evt_o,
  output logic          vs_evt_o,
  output logic          field_o,
  output logic [CW-1:0] idx_o,
  output logic [CW-1:0] len_o
);
  line_st_e      st_q;
  logic [CW-1:0] hoff_q, len_q, hcnt_q, idx_q, idx_nxt;
  logic          field_q, at_start;

  assign vs_evt_o = pix_en_i & vsync_i;
  assign hs_evt_o = pix_en_i & hsync_i & ~vsync_i;
  assign at_start = (st_q == LN_OFFSET) && (hcnt_q == hoff_q);
  assign slot_o   = pix_en_i & ~vsync_i & ~hsync_i & (at_start | (st_q == LN_ACTIVE));
  assign idx_nxt  = idx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= LN_IDLE;
      hoff_q  <= '0;
      len_q   <= '0;
      hcnt_q  <= '0;
      idx_q   <= '0;
      field_q <= 1'b0;
    end else if (vs_evt_o) begin
      hoff_q  <= hoff_i;
      len_q   <= len_i;
      field_q <= field_i;
      st_q    <= LN_IDLE;
      hcnt_q  <= '0;
      idx_q   <= '0;
    end else if (hs_evt_o) begin
      st_q   <= (len_q != '0) ? LN_OFFSET : LN_IDLE;
      hcnt_q <= '0;
      idx_q  <= '0;
    end else if (slot_o) begin
      if (advance_i) begin
        idx_q <= idx_nxt;
        st_q  <= (idx_nxt == len_q) ? LN_IDLE : LN_ACTIVE;
      end else begin
        st_q <= LN_ACTIVE;
      end
    end else if (pix_en_i && st_q == LN_OFFSET) begin
      hcnt_q <= hcnt_q + 1'b1;
    end
  end

  assign field_o = field_q;
  assign idx_o   = idx_q;
  assign len_o   = len_q;

  // R3: index never runs past the line length
  p_idx_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= len_q);
endmodule

// File: rtl/vuc_fill.sv
module vuc_fill
  import vuc_pkg::*;
#(
  parameter int unsigned PW = PIX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slot_i,
  input  logic          vs_evt_i,
  input  logic          line_mode_i,
  input  logic          hold_last_i,
  input  logic          idx_odd_i,
  input  logic          fifo_empty_i,
  input  logic [PW-1:0] fifo_data_i,
  output logic          take_o,
  output logic          fail_o,
  output logic          advance_o,
  output logic [PW-1:0] byte_o
);
  localparam logic [PW-1:0] G_Y = PW'(GREY_Y) << (PW - 8);
  localparam logic [PW-1:0] G_C = PW'(GREY_C) << (PW - 8);

  logic [PW-1:0] last_q, subst;

  assign take_o    = slot_i & ~fifo_empty_i;
  assign fail_o    = slot_i & fifo_empty_i & ~line_mode_i;
  assign advance_o = line_mode_i ? take_o : slot_i;

  always_comb begin
    if (hold_last_i) subst = last_q;
    else             subst = idx_odd_i ? G_Y : G_C;
    byte_o = fifo_empty_i ? subst : fifo_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_q <= G_C;
    else if (vs_evt_i) last_q <= G_C;
    else if (take_o)   last_q <= fifo_data_i;
  end

  // R9: frame start restores the chroma grey as last byte
  p_vs_last_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_evt_i |=> last_q == G_C);
endmodule

// File: rtl/vuc_discard.sv
module vuc_discard
  import vuc_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_en_i,
  input  logic          line_mode_i,
  input  logic          clr_i,
  input  logic          fail_i,
  input  logic [CW-1:0] len_i,
  input  logic          fifo_empty_i,
  input  logic          rd_busy_i,
  output logic          drop_o
);
  logic          pe_q, pe_q2;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pe_q  <= 1'b0;
      pe_q2 <= 1'b0;
    end else begin
      pe_q  <= pix_en_i;
      pe_q2 <= pe_q;
    end
  end

  // discard only in the free clock two after a pixel
  assign drop_o = pe_q2 & ~line_mode_i & ~rd_busy_i & ~fifo_empty_i & (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (fail_i && (cnt_q != len_i))  cnt_q <= cnt_q + 1'b1;
    else if (drop_o)                      cnt_q <= cnt_q - 1'b1;
  end

  p_drop_sat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= len_i);
  p_drop_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/vid_underflow_conceal.sv
module vid_underflow_conceal
  import vuc_pkg::*;
#(
  parameter int unsigned PW = PIX_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_en_i,
  input  logic          hsync_i,
  input  logic          vsync_i,
  input  logic          field_i,
  input  logic          cfg_line_mode_i,
  input  logic          cfg_hold_last_i,
  input  logic [CW-1:0] cfg_hoff_i,
  input  logic [CW-1:0] cfg_len_i,
  input  logic [PW-1:0] fifo_data_i,
  input  logic          fifo_empty_i,
  output logic          fifo_rd_o,
  output logic [PW-1:0] vid_data_o,
  output logic          vid_qual_o,
  output logic          vid_field_o
);
  logic          slot, hs_evt, vs_evt, take, fail, advance, drop;
  logic [CW-1:0] idx, len;
  logic [PW-1:0] out_byte;
  logic          rd_q, qual_q;
  logic [PW-1:0] data_q;

  vuc_timing #(.CW(CW)) i_timing (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pix_en_i (pix_en_i),
    .hsync_i  (hsync_i),
    .vsync_i  (vsync_i),
    .field_i  (field_i),
    .hoff_i   (cfg_hoff_i),
    .len_i    (cfg_len_i),
    .advance_i(advance),
    .slot_o   (slot),
    .hs_evt_o (hs_evt),
    .vs_evt_o (vs_evt),
    .field_o  (vid_field_o),
    .idx_o    (idx),
    .len_o    (len)
  );

  vuc_fill #(.PW(PW)) i_fill (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slot_i      (slot),
    .vs_evt_i    (vs_evt),
    .line_mode_i (cfg_line_mode_i),
    .hold_last_i (cfg_hold_last_i),
    .idx_odd_i   (idx[0]),
    .fifo_empty_i(fifo_empty_i),
    .fifo_data_i (fifo_data_i),
    .take_o      (take),
    .fail_o      (fail),
    .advance_o   (advance),
    .byte_o      (out_byte)
  );

  vuc_discard #(.CW(CW)) i_discard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pix_en_i    (pix_en_i),
    .line_mode_i (cfg_line_mode_i),
    .clr_i       (hs_evt | vs_evt),
    .fail_i      (fail),
    .len_i       (len),
    .fifo_empty_i(fifo_empty_i),
    .rd_busy_i   (rd_q),
    .drop_o      (drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      qual_q <= 1'b0;
      data_q <= '0;
    end else begin
      rd_q <= take | drop;
      if (pix_en_i) begin
        qual_q <= advance;
        if (advance) data_q <= out_byte;
      end
    end
  end

  assign fifo_rd_o  = rd_q;
  assign vid_qual_o = qual_q;
  assign vid_data_o = data_q;

  p_rd_spaced_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |=> !fifo_rd_o);
  p_pix_no_rd_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en_i |-> !fifo_rd_o);
  p_line_wait_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot && cfg_line_mode_i && fifo_empty_i) |=> !vid_qual_o);
endmodule

// File: tb/test_vid_underflow_conceal.sv
module test_vid_underflow_conceal;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        pix_en = 1'b0, hs = 1'b0, vs = 1'b0, fld = 1'b0;
  logic        line_mode = 1'b0, hold_last = 1'b0;
  logic [11:0] hoff = '0, len = '0;
  logic [7:0]  fmem [256];
  logic [7:0]  fwp = '0, frp = '0;
  logic        fifo_rd, qual, field_o;
  logic [7:0]  vdata;
  wire         fifo_empty = (fwp == frp);
  wire  [7:0]  fifo_data  = fmem[frp];

  vid_underflow_conceal i_vid_underflow_conceal (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(pix_en), .hsync_i(hs), .vsync_i(vs),
    .field_i(fld), .cfg_line_mode_i(line_mode), .cfg_hold_last_i(hold_last),
    .cfg_hoff_i(hoff), .cfg_len_i(len), .fifo_data_i(fifo_data),
    .fifo_empty_i(fifo_empty), .fifo_rd_o(fifo_rd), .vid_data_o(vdata),
    .vid_qual_o(qual), .vid_field_o(field_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (fifo_rd) frp <= frp + 8'd1;

  typedef struct { int slot; logic [7:0] val; string req; } exp_t;
  exp_t expq[$];
  int   n_chk = 0, n_bad = 0, dsl = 0, msl = -1;
  logic pe_prev = 1'b0;

  always @(posedge clk) pe_prev <= pix_en;

  // monitor: compare each pixel period against the scoreboard
  always @(negedge clk) begin
    if (pe_prev) begin
      msl++;
      if (qual) begin
        n_chk++;
        if (expq.size() == 0) begin
          n_bad++;
          $display("FAIL R3: unexpected byte %02h at slot %0d, expected none", vdata, msl);
        end else begin
          exp_t e;
          e = expq.pop_front();
          if (e.slot != msl || e.val != vdata) begin
            n_bad++;
            $display("FAIL %s: slot %0d data %02h, expected slot %0d data %02h",
                     e.req, msl, vdata, e.slot, e.val);
          end
        end
      end else if (expq.size() != 0 && expq[0].slot == msl) begin
        exp_t e;
        e = expq.pop_front();
        n_chk++; n_bad++;
        $display("FAIL %s: no byte at slot %0d, expected data %02h", e.req, msl, e.val);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  task automatic slot(input logic h, input logic v);
    @(negedge clk); pix_en = 1'b1; hs = h; vs = v;
    @(negedge clk); pix_en = 1'b0; hs = 1'b0; vs = 1'b0;
    @(negedge clk);
    @(negedge clk);
    dsl++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b0, 1'b0);
  endtask

  task automatic push(input logic [7:0] v);
    fmem[fwp] = v;
    fwp = fwp + 8'd1;
  endtask

  task automatic expect_at(input int s, input logic [7:0] v, input string req);
    exp_t e;
    e.slot = s; e.val = v; e.req = req;
    expq.push_back(e);
  endtask

  task automatic frame(input logic lm, input logic hl, input int ho, input int ln, input logic f);
    line_mode = lm; hold_last = hl; hoff = 12'(ho); len = 12'(ln); fld = f;
    slot(1'b0, 1'b1);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    int h;
    for (int i = 0; i < 256; i++) fmem[i] = '0;
    repeat (3) @(negedge clk);
    chk(qual == 1'b0 && fifo_rd == 1'b0, "R1", "qual/rd in reset", {qual, fifo_rd}, 0);
    chk(field_o == 1'b0 && vdata == 8'h00, "R1", "field/data in reset", {field_o, vdata}, 0);
    rst_n = 1'b1;
    // R1: no output before first vsync even with a sync and data
    push(8'hEE);
    slot(1'b1, 1'b0); idle(4);
    chk(fwp - frp == 8'd1, "R1", "fifo level before first vsync", fwp - frp, 1);
    frp = fwp;

    // R3/R4: plain line, offset 3, eight bytes
    frame(1'b0, 1'b0, 3, 8, 1'b1);
    fld = 1'b0;
    chk(field_o == 1'b1, "R2", "field after vsync", field_o, 1);
    for (int i = 0; i < 8; i++) push(8'hA0 + 8'(i));
    h = dsl;
    for (int i = 0; i < 8; i++) expect_at(h + 4 + i, 8'hA0 + 8'(i), "R3");
    slot(1'b1, 1'b0); idle(13);
    chk(fwp == frp, "R4", "fifo drained after line", fwp - frp, 0);

    // R2: config change mid-frame is ignored
    hoff = 12'd5; len = 12'd2;
    for (int i = 0; i < 8; i++) push(8'h30 + 8'(i));
    h = dsl;
    for (int i = 0; i < 8; i++) expect_at(h + 4 + i, 8'h30 + 8'(i), "R2");
    slot(1'b1, 1'b0); idle(13);
    chk(field_o == 1'b1, "R2", "field held mid-frame", field_o, 1);
    chk(fwp == frp, "R4", "fifo drained second line", fwp - frp, 0);

    // R5/R7: grey fill then catch-up discards
    frame(1'b0, 1'b0, 1, 8, 1'b0);
    chk(field_o == 1'b0, "R2", "field after second vsync", field_o, 0);
    push(8'hB0); push(8'hB1);
    h = dsl;
    expect_at(h + 2, 8'hB0, "R4");
    expect_at(h + 3, 8'hB1, "R4");
    expect_at(h + 4, 8'h80, "R5");
    expect_at(h + 5, 8'h10, "R5");
    expect_at(h + 6, 8'hB2, "R7");
    expect_at(h + 7, 8'hB4, "R7");
    expect_at(h + 8, 8'hB6, "R7");
    expect_at(h + 9, 8'hB7, "R7");
    slot(1'b1, 1'b0); idle(5);
    for (int i = 2; i < 8; i++) push(8'hB0 + 8'(i));
    idle(6);
    chk(fwp == frp, "R7", "fifo after catch-up", fwp - frp, 0);

    // R8: hsync drops pending discards
    frame(1'b0, 1'b0, 0, 4, 1'b0);
    push(8'hC0); push(8'hC1);
    h = dsl;
    expect_at(h + 1, 8'hC0, "R8");
    expect_at(h + 2, 8'hC1, "R8");
    expect_at(h + 3, 8'h80, "R5");
    expect_at(h + 4, 8'h10, "R5");
    slot(1'b1, 1'b0); idle(6);
    for (int i = 0; i < 4; i++) push(8'hD0 + 8'(i));
    h = dsl;
    for (int i = 0; i < 4; i++) expect_at(h + 1 + i, 8'hD0 + 8'(i), "R8");
    slot(1'b1, 1'b0); idle(6);
    chk(fwp == frp, "R8", "fifo after cleared line", fwp - frp, 0);

    // R6: last-byte fill
    frame(1'b0, 1'b1, 0, 6, 1'b0);
    push(8'h41); push(8'h42); push(8'h43);
    h = dsl;
    expect_at(h + 1, 8'h41, "R6");
    expect_at(h + 2, 8'h42, "R6");
    expect_at(h + 3, 8'h43, "R6");
    expect_at(h + 4, 8'h43, "R6");
    expect_at(h + 5, 8'h43, "R6");
    expect_at(h + 6, 8'h44, "R7");
    slot(1'b1, 1'b0); idle(5);
    push(8'h44); push(8'h45); push(8'h46);
    idle(4);
    chk(fwp == frp, "R7", "fifo after last-fill catch-up", fwp - frp, 0);

    // R9: vsync restores last byte to 0x80
    frame(1'b0, 1'b1, 2, 2, 1'b0);
    h = dsl;
    expect_at(h + 3, 8'h80, "R9");
    expect_at(h + 4, 8'h80, "R9");
    slot(1'b1, 1'b0); idle(6);
    // R9: vsync also clears the two pending misses
    push(8'h51); push(8'h52);
    frame(1'b0, 1'b0, 0, 2, 1'b0);
    h = dsl;
    expect_at(h + 1, 8'h51, "R9");
    expect_at(h + 2, 8'h52, "R9");
    slot(1'b1, 1'b0); idle(4);
    chk(fwp == frp, "R9", "fifo after vsync clear", fwp - frp, 0);

    // R10: line-memory mode waits
    frame(1'b1, 1'b0, 1, 4, 1'b0);
    push(8'h61);
    h = dsl;
    expect_at(h + 2, 8'h61, "R10");
    expect_at(h + 5, 8'h62, "R10");
    expect_at(h + 6, 8'h63, "R10");
    expect_at(h + 7, 8'h64, "R10");
    slot(1'b1, 1'b0); idle(4);
    push(8'h62); push(8'h63); push(8'h64);
    idle(6);
    chk(fwp == frp, "R10", "fifo after waited line", fwp - frp, 0);

    // R11: hsync restarts an unfinished line
    push(8'h71); push(8'h72);
    h = dsl;
    expect_at(h + 2, 8'h71, "R11");
    expect_at(h + 3, 8'h72, "R11");
    slot(1'b1, 1'b0); idle(4);
    for (int i = 1; i < 6; i++) push(8'h80 + 8'(i));
    h = dsl;
    for (int i = 0; i < 4; i++) expect_at(h + 2 + i, 8'h81 + 8'(i), "R11");
    slot(1'b1, 1'b0); idle(8);
    chk(fwp - frp == 8'd1, "R3", "fifo left after length reached", fwp - frp, 1);
    chk(fifo_data == 8'h85, "R3", "fifo head after line", fifo_data, 8'h85);

    chk(expq.size() == 0, "R4", "expected bytes not seen", expq.size(), 0);
    summary();
  end
endmodule